// File: doc/BRIEF.md
# Serial-Controlled Converter Interface Sequencer

This block is the device-side digital front end of a multichannel converter driven over a serial link. A host drives a chip select, an I/O clock and a serial input. The block returns a serial output with an output enable and an end-of-conversion flag. Each I/O cycle carries an 8-bit command into the block. At the same time, the result of the previous conversion leaves the block serially.

The command holds four fields. Bits 7..4 are the channel address. Bits 3..2 select the cycle length. Bit 1 asks for least-significant-bit-first order. Bit 0 asks for the bipolar code. The length field acts on the cycle in which it arrives. Order and number format act on the result read out in a later cycle. At the last falling I/O clock edge of a cycle the block drops end-of-conversion and pulses a start strobe. A converter outside the block answers with a done strobe and a 12-bit result. The block then formats that result and raises end-of-conversion again.

The block runs on a fast system clock. It oversamples chip select and the I/O clock through synchronizers and acts on the edges it detects there.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset, `eoc` is 1, and `conv_start`, `pwr_down`, `dbg_abort` and `dbg_bitcnt` are 0. `sdo_oe` is 0 while `cs_n` is high. The stored command is zero, which means a 12-clock cycle, MSB-first order and unipolar format.
- R2: The command is taken MSB first from `sdi` on the first eight rising I/O clock edges of a cycle. `sdi` is ignored after the eighth rising edge.
- R3: The command's bits 3..2 set the length of the cycle they arrive in: 01 gives 8 clocks, 11 gives 16, and 00 or 10 give 12. On the last falling edge of that cycle, `eoc` goes low and `conv_start` pulses for one cycle. `eoc` stays high before that edge.
- R4: `sdo` moves to the next bit on each falling I/O clock edge. `dbg_bitcnt` counts the falling edges seen in the current cycle.
- R5: With MSB-first order, the 12 result bits leave from bit 11 down to bit 0. In a 16-clock cycle four zeros follow them. In an 8-clock cycle only bits 11..4 are sent.
- R6: With LSB-first order, a 12-clock cycle sends bits 0..11. A 16-clock cycle sends four zeros first and then bits 0..11. An 8-clock cycle sends bits 4..11.
- R7: The bipolar format sends the result with bit 11 inverted. The unipolar format sends it unchanged.
- R8: The word read in a cycle is the result of the last conversion. It is formatted with the order, format and length of the command that launched that conversion.
- R9: While `eoc` is low, `sdo` is 0. On the system clock edge after `conv_done` is sampled high, `eoc` goes high and the first bit of the new result appears on `sdo`.
- R10: While `cs_n` is high, `sdo_oe` is 0 and I/O clock edges are ignored. A falling `cs_n` clears the bit counters and presents the first bit of the stored word again.
- R11: On the 4th falling edge of a cycle, `conv_chan` takes the address and `sample_en` rises. `sample_en` falls on the last falling edge.
- R12: Address 1110 raises `pwr_down` on the 4th falling edge. The cycle still runs to its full length, but it produces no `conv_start`, and `eoc` stays high. `pwr_down` clears on the 4th falling edge of a later cycle that carries another address.
- R13: If `cs_n` rises in the middle of a cycle, `dbg_abort` is set. That cycle starts no conversion, and its command is not used. The next falling `cs_n` clears `dbg_abort`.
- R14: While `eoc` is low, I/O clock edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| io_clk | input | 1 | I/O clock from the host |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial result output |
| sdo_oe | output | 1 | Output enable for `sdo` (low means high impedance) |
| eoc | output | 1 | End-of-conversion flag |
| conv_start | output | 1 | One-cycle strobe that starts a conversion |
| sample_en | output | 1 | High while the selected channel is being sampled |
| conv_chan | output | 4 | Channel address for the sampler |
| pwr_down | output | 1 | Power-down request |
| conv_done | input | 1 | Strobe from the converter: the result is valid |
| conv_result | input | 12 | Unipolar conversion result |
| dbg_bitcnt | output | 5 | Falling-edge count in the current cycle |
| dbg_abort | output | 1 | Set when the last cycle was cut short by chip select |

## Verification
An edge on `io_clk` or `cs_n` reaches the block's registers on the third system clock edge after the input changes: two synchronizer stages and one state register. The bench therefore holds each I/O clock level for six system cycles and reads `sdo`, `dbg_bitcnt`, `sample_en` and `pwr_down` on a falling system clock edge after that hold. `eoc` and the first result bit follow the edge on which `conv_done` is sampled, so the bench polls `eoc` on falling system clock edges and checks `sdo` on the next one. Expected words come from a per-bit formula. It takes the result and command of the previous conversion and runs over every length, order and format.

// File: rtl/adc_serial_seq.sv
module adc_serial_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        io_clk,
  input  logic        sdi,
  output logic        sdo,
  output logic        sdo_oe,
  output logic        eoc,
  output logic        conv_start,
  output logic        sample_en,
  output logic [3:0]  conv_chan,
  output logic        pwr_down,
  input  logic        conv_done,
  input  logic [11:0] conv_result,
  output logic [4:0]  dbg_bitcnt,
  output logic        dbg_abort
);
  localparam int RES_W = 12;
  localparam int OUT_W = RES_W + 4;
  localparam int CMD_W = 8;
  localparam logic [3:0] CMD_N   = 4'(CMD_W);
  localparam logic [3:0] PD_ADDR = 4'hE;

  logic [SYNC_STAGES-1:0] clk_sync, cs_sync;
  logic clk_q, cs_q;
  logic [3:0] rise_cnt;
  logic [4:0] fall_cnt;
  logic [CMD_W-1:0] cmd_sr;
  logic [3:0] cmd_reg;
  logic [OUT_W-1:0] out_word, out_sr, fmt;
  logic [RES_W-1:0] res_f, res_r;
  logic [4:0] frame_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      cs_sync  <= '1;
      clk_q    <= 1'b0;
      cs_q     <= 1'b1;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], io_clk};
      cs_sync  <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      clk_q    <= clk_sync[SYNC_STAGES-1];
      cs_q     <= cs_sync[SYNC_STAGES-1];
    end
  end

  wire clk_s    = clk_sync[SYNC_STAGES-1];
  wire cs_s     = cs_sync[SYNC_STAGES-1];
  wire cs_fall  = cs_q & ~cs_s;
  wire cs_rise  = ~cs_q & cs_s;
  wire live     = ~cs_s & ~cs_q & eoc;
  wire io_rise  = live & clk_s & ~clk_q;
  wire io_fall  = live & ~clk_s & clk_q;
  wire in_frame = (rise_cnt != 4'd0) | (fall_cnt != 5'd0);

  assign frame_len = (cmd_sr[3:2] == 2'b01) ? 5'd8 :
                     (cmd_sr[3:2] == 2'b11) ? 5'd16 : 5'd12;
  wire last_fall = io_fall & (fall_cnt + 5'd1 == frame_len);

  assign res_f = {conv_result[RES_W-1] ^ cmd_reg[0], conv_result[RES_W-2:0]};

  always_comb
    for (int i = 0; i < RES_W; i++) res_r[i] = res_f[RES_W-1-i];

  always_comb
    case ({cmd_reg[1], cmd_reg[3:2]})
      3'b101:        fmt = {res_r[7:0], 8'h00};
      3'b111:        fmt = {4'h0, res_r};
      3'b100, 3'b110: fmt = {res_r, 4'h0};
      default:       fmt = {res_f, 4'h0};
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt   <= '0;
      fall_cnt   <= '0;
      cmd_sr     <= '0;
      cmd_reg    <= '0;
      out_word   <= '0;
      out_sr     <= '0;
      eoc        <= 1'b1;
      conv_start <= 1'b0;
      sample_en  <= 1'b0;
      conv_chan  <= '0;
      pwr_down   <= 1'b0;
      dbg_abort  <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (cs_fall) begin
        rise_cnt  <= '0;
        fall_cnt  <= '0;
        out_sr    <= out_word;
        dbg_abort <= 1'b0;
      end else if (cs_rise) begin
        rise_cnt  <= '0;
        fall_cnt  <= '0;
        sample_en <= 1'b0;
        if (in_frame) dbg_abort <= 1'b1;
      end else begin
        if (io_rise && rise_cnt != CMD_N) begin
          cmd_sr   <= {cmd_sr[CMD_W-2:0], sdi};
          rise_cnt <= rise_cnt + 4'd1;
        end
        if (io_fall) begin
          out_sr <= {out_sr[OUT_W-2:0], 1'b0};
          if (last_fall) begin
            rise_cnt  <= '0;
            fall_cnt  <= '0;
            cmd_reg   <= cmd_sr[3:0];
            sample_en <= 1'b0;
            if (!pwr_down) begin
              eoc        <= 1'b0;
              conv_start <= 1'b1;
            end
          end else begin
            fall_cnt <= fall_cnt + 5'd1;
            if (fall_cnt == 5'd3) begin
              conv_chan <= cmd_sr[3:0];
              pwr_down  <= (cmd_sr[3:0] == PD_ADDR);
              sample_en <= (cmd_sr[3:0] != PD_ADDR);
            end
          end
        end
      end
      if (!eoc && conv_done) begin
        out_word <= fmt;
        out_sr   <= fmt;
        eoc      <= 1'b1;
      end
    end
  end

  assign sdo        = eoc & out_sr[OUT_W-1];
  assign sdo_oe     = ~cs_q;
  assign dbg_bitcnt = fall_cnt;
endmodule

module adc_serial_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sdo,
  input logic       sdo_oe,
  input logic       eoc,
  input logic       conv_start,
  input logic       sample_en,
  input logic       pwr_down,
  input logic       conv_done,
  input logic       dbg_abort,
  input logic [4:0] dbg_bitcnt
);
  a_r9_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> !sdo);
  a_r9_eoc_rises_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(conv_done));
  a_r3_start_with_eoc_low: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !eoc);
  a_r12_no_start_in_pd: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !pwr_down);
  a_r11_no_sampling_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> !sample_en);
  a_r13_abort_blocks_start: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_abort |-> !conv_start);
  a_r10_enable_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> dbg_bitcnt == 5'd0);
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_bitcnt <= 5'd15);
endmodule

bind adc_serial_seq adc_serial_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc),
  .conv_start(conv_start), .sample_en(sample_en), .pwr_down(pwr_down),
  .conv_done(conv_done), .dbg_abort(dbg_abort), .dbg_bitcnt(dbg_bitcnt)
);

// File: tb/adc_serial_seq_tb.sv
`timescale 1ns/1ps
module adc_serial_seq_tb;
  logic clk = 0, rst_n = 0, cs_n = 1, io_clk = 0, sdi = 0;
  logic sdo, sdo_oe, eoc, conv_start, sample_en, pwr_down, dbg_abort;
  logic [3:0] conv_chan;
  logic [4:0] dbg_bitcnt;
  logic conv_done = 0;
  logic [11:0] conv_result = 0;

  int n_chk = 0, n_bad = 0, starts = 0, cd = 0, conv_lat = 20;
  bit finished = 0;
  logic [11:0] exp_res = 0;
  logic [7:0]  exp_cmd = 0;

  always #4 clk = ~clk;

  adc_serial_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .eoc(eoc), .conv_start(conv_start),
    .sample_en(sample_en), .conv_chan(conv_chan), .pwr_down(pwr_down),
    .conv_done(conv_done), .conv_result(conv_result),
    .dbg_bitcnt(dbg_bitcnt), .dbg_abort(dbg_abort)
  );

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      starts <= starts + 1;
      cd <= conv_lat;
    end else if (cd > 1) cd <= cd - 1;
    else if (cd == 1) begin
      cd <= 0;
      conv_done <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int len_of(input logic [1:0] l);
    return (l == 2'b01) ? 8 : (l == 2'b11) ? 16 : 12;
  endfunction

  function automatic logic exp_bit(input logic [11:0] r, input logic [7:0] c, input int i);
    logic [11:0] f;
    f = c[0] ? (r ^ 12'h800) : r;
    if (!c[1]) return (i <= 11) ? f[11-i] : 1'b0;
    case (c[3:2])
      2'b01:   return (i < 8) ? f[i+4] : 1'b0;
      2'b11:   return (i >= 4 && i < 16) ? f[i-4] : 1'b0;
      default: return (i < 12) ? f[i] : 1'b0;
    endcase
  endfunction

  task automatic release_cs();
    cs_n = 1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(sdo_oe == 1'b0, "R10", "sdo_oe with cs high", sdo_oe, 0);
  endtask

  task automatic run_frame(input logic [7:0] cmd, input logic [11:0] res,
                           input int stop_after, input int busy_toggles);
    int nclk, s0;
    bit pd;
    logic [15:0] got, expw;
    pd = (cmd[7:4] == 4'hE);
    nclk = (stop_after > 0) ? stop_after : len_of(cmd[3:2]);
    conv_result = res;
    if (cs_n) begin
      cs_n = 0;
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk(dbg_bitcnt == 0 && dbg_abort == 0, "R13", "count/abort after cs fall",
          {dbg_bitcnt, dbg_abort}, 0);
      chk(sdo_oe == 1'b1, "R10", "sdo_oe with cs low", sdo_oe, 1);
    end
    s0 = starts;
    got = 0;
    expw = 0;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk);
      got[i] = sdo;
      expw[i] = exp_bit(exp_res, exp_cmd, i);
      if (i == nclk - 1 && stop_after == 0)
        chk(eoc == 1'b1, "R3", "eoc before last fall", eoc, 1);
      sdi = (i < 8) ? cmd[7-i] : ~cmd[i % 8];
      io_clk = 1;
      repeat (6) @(posedge clk);
      io_clk = 0;
      repeat (6) @(posedge clk);
      @(negedge clk);
      if (i == 3) begin
        if (pd) chk(pwr_down == 1'b1 && sample_en == 1'b0, "R12", "power-down at 4th fall",
                    {pwr_down, sample_en}, 2);
        else chk(pwr_down == 1'b0 && sample_en == 1'b1 && conv_chan == cmd[7:4], "R11",
                 "sampling/channel at 4th fall", {pwr_down, sample_en, conv_chan},
                 {2'b01, cmd[7:4]});
      end
      if (i == 4 && nclk > 5)
        chk(dbg_bitcnt == 5, "R4", "falling edge count", dbg_bitcnt, 5);
    end
    chk(got == expw, "R5/R6/R7/R8", "readout word", got, expw);
    if (stop_after > 0) begin
      cs_n = 1;
      repeat (8) @(posedge clk);
      @(negedge clk);
      chk(dbg_abort == 1'b1 && starts == s0, "R13", "abort flag / no start",
          {dbg_abort, 8'(starts - s0)}, 9'h100);
      return;
    end
    @(negedge clk);
    if (pd) begin
      chk(starts == s0 && eoc == 1'b1, "R12", "no conversion after power-down cycle",
          {eoc, 8'(starts - s0)}, 9'h100);
      return;
    end
    chk(starts == s0 + 1 && eoc == 1'b0, "R3", "start pulse and eoc low",
        {eoc, 8'(starts - s0)}, 9'h001);
    chk(sdo == 1'b0 && sample_en == 1'b0, "R9", "sdo low / sampling off while busy",
        {sdo, sample_en}, 0);
    for (int t = 0; t < busy_toggles; t++) begin
      sdi = t[0];
      io_clk = 1;
      repeat (6) @(posedge clk);
      io_clk = 0;
      repeat (6) @(posedge clk);
    end
    if (busy_toggles > 0) begin
      @(negedge clk);
      chk(dbg_bitcnt == 0 && eoc == 1'b0, "R14", "edges ignored while busy",
          {dbg_bitcnt, eoc}, 0);
    end
    for (int w = 0; w < 3000 && !eoc; w++) @(negedge clk);
    chk(eoc == 1'b1, "R9", "eoc returns", eoc, 1);
    @(negedge clk);
    chk(sdo == exp_bit(res, cmd, 0), "R9", "first bit at eoc rise", sdo, exp_bit(res, cmd, 0));
    exp_res = res;
    exp_cmd = cmd;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(eoc == 1 && sdo_oe == 0 && conv_start == 0 && pwr_down == 0 &&
        dbg_bitcnt == 0 && dbg_abort == 0, "R1", "reset state",
        {eoc, sdo_oe, conv_start, pwr_down, dbg_bitcnt, dbg_abort}, 10'h200);
    for (int t = 0; t < 3; t++) begin
      io_clk = 1;
      repeat (6) @(posedge clk);
      io_clk = 0;
      repeat (6) @(posedge clk);
    end
    @(negedge clk);
    chk(dbg_bitcnt == 0, "R10", "edges ignored with cs high", dbg_bitcnt, 0);

    // R2 R3 R5 R6 R7 R8: sweep of lengths, orders, formats and result corners
    for (int l = 0; l < 4; l++)
      for (int o = 0; o < 2; o++)
        for (int b = 0; b < 2; b++)
          for (int r = 0; r < 3; r++) begin
            logic [3:0] addr;
            logic [11:0] res;
            addr = 4'((l * 4 + o * 2 + b + r) % 11);
            res = (r == 0) ? 12'h000 : (r == 1) ? 12'hFFF :
                  12'((l * 1000 + o * 517 + b * 2049 + 1371 + 77) % 4096);
            run_frame({addr, 2'(l), 1'(o), 1'(b)}, res, 0, 0);
            if (r != 2) release_cs();
          end
    release_cs();

    // R12: power-down cycle, then a normal cycle clears it
    run_frame(8'hE5, 12'h123, 0, 0);
    release_cs();
    run_frame(8'h3C, 12'hA5C, 0, 0);
    release_cs();

    // R13 and R10: abort mid-cycle, then full reread of stored word
    run_frame(8'h7B, 12'h0F0, 5, 0);
    run_frame(8'h16, 12'h8E1, 0, 0);
    release_cs();

    // R14: clocks during conversion are ignored
    conv_lat = 400;
    run_frame(8'h2F, 12'h7FF, 0, 4);
    conv_lat = 20;
    run_frame(8'h40, 12'h801, 0, 0);
    release_cs();
    run_frame(8'h94, 12'h000, 0, 0);
    release_cs();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule